// File: doc/BRIEF.md
# Reset time-out sequencer

This block keeps a small processor core in reset, or keeps it stalled, until the delays needed after a reset or a wake have run out. After a power-on, brown-out, watchdog or software reset it runs a chain of up to three waits. The first is a power-up wait counted in timebase ticks. The second is an oscillator start-up count of clock periods. The third is an optional PLL lock wait counted in ticks. The clock mode, the power-up-wait enable and the PLL enable decide which of the three waits take part.

A wake from sleep skips the power-up wait. The external reset pin holds the core for as long as it is asserted, but the waits keep running underneath it. The block also keeps a small register of cause flags, which software may overwrite, and it supplies the address at which the core should resume.

All event strobes and the pin level pass through a synchronizer into the oscillator clock domain. Events are then taken on their rising edge. The power-on input clears the block asynchronously and also asserts the core hold asynchronously.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1 asynchronously, `flags_o` reads 5'b11100 and `start_pc_o` is 0. Flag bits are [4] reset-instruction, [3] time-out, [2] power-down, [1] brown-out, [0] power-on, with 0 marking that the event took place. After release the power-up chain runs.
- R2: Clock-mode codes are 0 low-speed crystal, 1 high-speed crystal, 2 external clock and 3 RC. In modes 0 and 1, a brown-out, watchdog or software reset with `pwrt_en_i`=1 holds the core for PWRT_TICKS ticks and then for OST_CYCLES clocks.
- R3: In modes 0 and 1 with `pwrt_en_i`=0, such a reset holds the core for exactly OST_CYCLES clocks.
- R4: In modes 2 and 3, such a reset holds the core for PWRT_TICKS ticks when `pwrt_en_i`=1. When `pwrt_en_i`=0 it holds the core for a single clock.
- R5: The PLL wait of PLL_TICKS ticks follows the start-up count only in mode 1 with `pll_en_i`=1. In every other mode `pll_en_i` has no effect.
- R6: A watchdog or interrupt wake strobe counts only while `sleep_i`=1. In modes 0 and 1 it stalls the core for OST_CYCLES clocks, plus the PLL wait under R5. In modes 2 and 3 it does not stall the core. With `sleep_i`=0 the strobe changes neither `core_rst_o`, `flags_o` nor `start_pc_o`.
- R7: While the synchronized pin is high, `core_rst_o` is 1. The waits keep running during that time. If they have already expired, `core_rst_o` falls on the third clock edge after the pin falls.
- R8: A software reset clears bit 4. A watchdog reset clears bit 3 and sets bit 2. The external pin outside sleep leaves all flags unchanged.
- R9: A brown-out clears bit 1, sets bits 4, 3 and 2, and leaves bit 0 unchanged. A watchdog wake clears bits 3 and 2. An interrupt wake, or the pin asserted in sleep, sets bit 3 and clears bit 2.
- R10: Every reset, including the pin asserted in sleep, loads `start_pc_o` with 0. A watchdog wake loads `pc_i`+2. An interrupt wake loads VEC_HI (0x08) or VEC_LO (0x18) as chosen by `irq_hi_i` when `irq_en_i`=1, and `pc_i`+2 when `irq_en_i`=0.
- R11: A reset event that arrives during a wait restarts the chain from the first phase that applies to that event.
- R12: When `flag_wr_i`=1, `flags_o` takes `flag_wdata_i` on the next edge. An event in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_stb_i | input | 1 | Brown-out reset strobe |
| wdt_rst_stb_i | input | 1 | Watchdog reset strobe |
| sw_rst_stb_i | input | 1 | Software reset strobe |
| pin_rst_i | input | 1 | External reset pin level, 1 = asserted |
| wake_wdt_stb_i | input | 1 | Watchdog wake strobe |
| wake_irq_stb_i | input | 1 | Interrupt wake strobe |
| sleep_i | input | 1 | Core is asleep |
| irq_en_i | input | 1 | Interrupts enabled |
| irq_hi_i | input | 1 | Waking interrupt is high priority |
| osc_mode_i | input | 2 | Clock mode code |
| pwrt_en_i | input | 1 | Power-up wait enable |
| pll_en_i | input | 1 | PLL enable |
| tick_i | input | 1 | Timebase tick, one clock wide |
| pc_i | input | ADDR_W | Current program counter |
| flag_wr_i | input | 1 | Software write of the flags |
| flag_wdata_i | input | 5 | Value to write |
| core_rst_o | output | 1 | Core reset or stall |
| flags_o | output | 5 | Cause flags |
| start_pc_o | output | ADDR_W | Address at which the core resumes |

## Verification
A strobe driven before edge k reaches the event decoder after two synchronizer edges. Flags, address and phase therefore change at edge k+2, and `core_rst_o` rises at that same edge. Tick-based waits can only be placed within one tick period, because the tick phase relative to the strobe is free. The bench therefore counts the clocks `core_rst_o` spends high in a window that outlasts the longest chain. It compares that count with a band of one tick period plus a cycle of margin, or with an exact count when only clock-counted phases take part. Pin release is checked at the exact edge: still held after two edges and released after the third.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   typedef enum logic [1:0] {
      OSC_XT  = 2'd0,
      OSC_HS  = 2'd1,
      OSC_EXT = 2'd2,
      OSC_RC  = 2'd3
   } osc_mode_e;

   typedef enum logic [2:0] {
      PH_BOOT = 3'd0,
      PH_PWRT = 3'd1,
      PH_OST  = 3'd2,
      PH_PLL  = 3'd3,
      PH_DONE = 3'd4
   } phase_e;

   typedef enum logic [2:0] {
      EV_NONE     = 3'd0,
      EV_BOR      = 3'd1,
      EV_WDT      = 3'd2,
      EV_SW       = 3'd3,
      EV_PIN      = 3'd4,
      EV_PIN_SLP  = 3'd5,
      EV_WAKE_WDT = 3'd6,
      EV_WAKE_IRQ = 3'd7
   } evt_e;

   localparam int FLAG_W = 5;
   localparam int FL_POR = 0;
   localparam int FL_BOR = 1;
   localparam int FL_PD  = 2;
   localparam int FL_TO  = 3;
   localparam int FL_RI  = 4;

   localparam logic [FLAG_W-1:0] FLAGS_AT_POR = 5'b11100;

   function automatic logic evt_restarts_full(evt_e e);
      return (e == EV_BOR) || (e == EV_WDT) || (e == EV_SW);
   endfunction

   function automatic logic evt_is_wake(evt_e e);
      return (e == EV_PIN_SLP) || (e == EV_WAKE_WDT) || (e == EV_WAKE_IRQ);
   endfunction

   function automatic logic evt_is_reset(evt_e e);
      return evt_restarts_full(e) || (e == EV_PIN) || (e == EV_PIN_SLP);
   endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i)      stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= d_i;
         else            stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rst_seq_evt.sv
module rst_seq_evt
   import rst_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bor_i,
   input  logic wdt_i,
   input  logic sw_i,
   input  logic pin_i,
   input  logic wwdt_i,
   input  logic wirq_i,
   input  logic sleep_i,
   output evt_e evt_o,
   output logic pin_lvl_o
);
   localparam int N_IN  = 6;
   localparam int I_BOR = 0;
   localparam int I_WDT = 1;
   localparam int I_SW  = 2;
   localparam int I_PIN = 3;
   localparam int I_WWD = 4;
   localparam int I_WIR = 5;

   logic [N_IN-1:0] raw, syn, prev_q, rise;

   assign raw = {wirq_i, wwdt_i, pin_i, sw_i, wdt_i, bor_i};

   rst_seq_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (raw),
      .q_o   (syn)
   );

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) prev_q <= '0;
      else       prev_q <= syn;
   end

   assign rise      = syn & ~prev_q;
   assign pin_lvl_o = syn[I_PIN];

   always_comb begin
      evt_o = EV_NONE;
      if (rise[I_BOR])                 evt_o = EV_BOR;
      else if (rise[I_WDT])            evt_o = EV_WDT;
      else if (rise[I_SW])             evt_o = EV_SW;
      else if (rise[I_PIN] && sleep_i) evt_o = EV_PIN_SLP;
      else if (rise[I_PIN])            evt_o = EV_PIN;
      else if (rise[I_WWD] && sleep_i) evt_o = EV_WAKE_WDT;
      else if (rise[I_WIR] && sleep_i) evt_o = EV_WAKE_IRQ;
   end

   p_one_cause_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(rise[I_WDT:I_BOR]) > 1 |-> evt_o == EV_BOR || evt_o == EV_WDT);
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer
   import rst_seq_pkg::*;
#(
   parameter int PWRT_TICKS  = 72,
   parameter int OST_CYCLES  = 1024,
   parameter int PLL_TICKS   = 2,
   parameter bit PLL_SUPPORT = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      tick_i,
   input  evt_e      evt_i,
   input  osc_mode_e mode_i,
   input  logic      pwrt_en_i,
   input  logic      pll_en_i,
   output phase_e    phase_d_o
);
   localparam int MAX_A  = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
   localparam int MAX_C  = (MAX_A > PLL_TICKS) ? MAX_A : PLL_TICKS;
   localparam int CNT_W  = $clog2(MAX_C + 1);
   localparam logic [CNT_W-1:0] PWRT_LAST = CNT_W'(PWRT_TICKS - 1);
   localparam logic [CNT_W-1:0] OST_LAST  = CNT_W'(OST_CYCLES - 1);
   localparam logic [CNT_W-1:0] PLL_LAST  = CNT_W'(PLL_TICKS - 1);

   phase_e           phase_q, phase_d;
   phase_e           full_start, wake_start, after_pwrt, after_ost;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             crystal, pll_use, restart;

   assign crystal = (mode_i == OSC_XT) || (mode_i == OSC_HS);

   if (PLL_SUPPORT) begin : g_pll
      assign pll_use = (mode_i == OSC_HS) && pll_en_i;
   end else begin : g_no_pll
      assign pll_use = 1'b0;
   end

   always_comb begin
      full_start = pwrt_en_i ? PH_PWRT : (crystal ? PH_OST : PH_DONE);
      wake_start = crystal ? PH_OST : PH_DONE;
      after_pwrt = crystal ? PH_OST : PH_DONE;
      after_ost  = pll_use ? PH_PLL : PH_DONE;
   end

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      restart = 1'b0;
      case (phase_q)
         PH_BOOT: phase_d = full_start;
         PH_PWRT: if (tick_i) begin
            if (cnt_q == PWRT_LAST) phase_d = after_pwrt;
            else                    cnt_d   = cnt_q + 1'b1;
         end
         PH_OST: begin
            if (cnt_q == OST_LAST) phase_d = after_ost;
            else                   cnt_d   = cnt_q + 1'b1;
         end
         PH_PLL: if (tick_i) begin
            if (cnt_q == PLL_LAST) phase_d = PH_DONE;
            else                   cnt_d   = cnt_q + 1'b1;
         end
         default: ;
      endcase
      if (evt_restarts_full(evt_i)) begin
         phase_d = full_start;
         restart = 1'b1;
      end else if (evt_is_wake(evt_i)) begin
         phase_d = wake_start;
         restart = 1'b1;
      end
      if (restart || (phase_d != phase_q)) cnt_d = '0;
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         phase_q <= PH_BOOT;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign phase_d_o = phase_d;

   p_pwrt_waits_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q == PH_PWRT && !tick_i && evt_i == EV_NONE) |=> phase_q == PH_PWRT);

   p_ost_ends_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q == PH_OST && cnt_q == OST_LAST && evt_i == EV_NONE)
      |=> (phase_q == PH_PLL || phase_q == PH_DONE));

   p_pll_only_hs_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(phase_q == PH_PLL) |-> ($past(mode_i) == OSC_HS && $past(pll_en_i)));

   p_restart_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      (evt_restarts_full(evt_i) && pwrt_en_i) |=> (phase_q == PH_PWRT && cnt_q == '0));

   p_wake_skips_pwrt_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_is_wake(evt_i) |=> phase_q != PH_PWRT);
endmodule

// File: rtl/rst_seq_flags.sv
module rst_seq_flags
   import rst_seq_pkg::*;
#(
   parameter int              ADDR_W = 21,
   parameter logic [ADDR_W-1:0] VEC_HI = 'h08,
   parameter logic [ADDR_W-1:0] VEC_LO = 'h18
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  evt_e              evt_i,
   input  logic              irq_en_i,
   input  logic              irq_hi_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              wr_i,
   input  logic [FLAG_W-1:0] wdata_i,
   output logic [FLAG_W-1:0] flags_o,
   output logic [ADDR_W-1:0] start_pc_o
);
   localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

   logic [FLAG_W-1:0] flags_q, flags_d;
   logic [ADDR_W-1:0] pc_q, pc_d;
   logic [ADDR_W-1:0] resume_pc;

   assign resume_pc = pc_i + PC_STEP;

   always_comb begin
      flags_d = flags_q;
      pc_d    = pc_q;
      case (evt_i)
         EV_BOR: begin
            flags_d[FL_BOR] = 1'b0;
            flags_d[FL_RI]  = 1'b1;
            flags_d[FL_TO]  = 1'b1;
            flags_d[FL_PD]  = 1'b1;
            pc_d            = '0;
         end
         EV_WDT: begin
            flags_d[FL_TO] = 1'b0;
            flags_d[FL_PD] = 1'b1;
            pc_d           = '0;
         end
         EV_SW: begin
            flags_d[FL_RI] = 1'b0;
            pc_d           = '0;
         end
         EV_PIN: pc_d = '0;
         EV_PIN_SLP: begin
            flags_d[FL_TO] = 1'b1;
            flags_d[FL_PD] = 1'b0;
            pc_d           = '0;
         end
         EV_WAKE_WDT: begin
            flags_d[FL_TO] = 1'b0;
            flags_d[FL_PD] = 1'b0;
            pc_d           = resume_pc;
         end
         EV_WAKE_IRQ: begin
            flags_d[FL_TO] = 1'b1;
            flags_d[FL_PD] = 1'b0;
            if (irq_en_i) pc_d = irq_hi_i ? VEC_HI : VEC_LO;
            else          pc_d = resume_pc;
         end
         default: if (wr_i) flags_d = wdata_i;
      endcase
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         flags_q <= FLAGS_AT_POR;
         pc_q    <= '0;
      end else begin
         flags_q <= flags_d;
         pc_q    <= pc_d;
      end
   end

   assign flags_o    = flags_q;
   assign start_pc_o = pc_q;

   p_sw_clears_ri_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_i == EV_SW |=> !flags_q[FL_RI]);

   p_bor_keeps_por_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_i == EV_BOR |=> (!flags_q[FL_BOR] && $stable(flags_q[FL_POR])));

   p_vector_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (evt_i == EV_WAKE_IRQ && irq_en_i) |=> (pc_q == VEC_HI || pc_q == VEC_LO));

   p_quiet_hold_r12: assert property (@(posedge clk_i) disable iff (rst_i)
      (evt_i == EV_NONE && !wr_i) |=> $stable(flags_q));
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
   import rst_seq_pkg::*;
#(
   parameter int              PWRT_TICKS  = 72,
   parameter int              OST_CYCLES  = 1024,
   parameter int              PLL_TICKS   = 2,
   parameter bit              PLL_SUPPORT = 1'b1,
   parameter int              SYNC_STAGES = 2,
   parameter int              ADDR_W      = 21,
   parameter logic [ADDR_W-1:0] VEC_HI    = 'h08,
   parameter logic [ADDR_W-1:0] VEC_LO    = 'h18
) (
   input  logic              clk_osc_i,
   input  logic              por_i,
   input  logic              bor_stb_i,
   input  logic              wdt_rst_stb_i,
   input  logic              sw_rst_stb_i,
   input  logic              pin_rst_i,
   input  logic              wake_wdt_stb_i,
   input  logic              wake_irq_stb_i,
   input  logic              sleep_i,
   input  logic              irq_en_i,
   input  logic              irq_hi_i,
   input  logic [1:0]        osc_mode_i,
   input  logic              pwrt_en_i,
   input  logic              pll_en_i,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              flag_wr_i,
   input  logic [4:0]        flag_wdata_i,
   output logic              core_rst_o,
   output logic [4:0]        flags_o,
   output logic [ADDR_W-1:0] start_pc_o
);
   if (PWRT_TICKS < 1) begin : g_bad_pwrt
      $error("PWRT_TICKS must be at least 1");
   end
   if (OST_CYCLES < 2) begin : g_bad_ost
      $error("OST_CYCLES must be at least 2");
   end
   if (PLL_TICKS < 1) begin : g_bad_pll
      $error("PLL_TICKS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must hold both vectors");
   end

   evt_e      evt;
   phase_e    phase_d;
   logic      pin_lvl;
   logic      core_rst_q;
   osc_mode_e mode;

   assign mode = osc_mode_e'(osc_mode_i);

   rst_seq_evt #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
      .clk_i     (clk_osc_i),
      .rst_i     (por_i),
      .bor_i     (bor_stb_i),
      .wdt_i     (wdt_rst_stb_i),
      .sw_i      (sw_rst_stb_i),
      .pin_i     (pin_rst_i),
      .wwdt_i    (wake_wdt_stb_i),
      .wirq_i    (wake_irq_stb_i),
      .sleep_i   (sleep_i),
      .evt_o     (evt),
      .pin_lvl_o (pin_lvl)
   );

   rst_seq_timer #(
      .PWRT_TICKS  (PWRT_TICKS),
      .OST_CYCLES  (OST_CYCLES),
      .PLL_TICKS   (PLL_TICKS),
      .PLL_SUPPORT (PLL_SUPPORT)
   ) u_timer (
      .clk_i     (clk_osc_i),
      .rst_i     (por_i),
      .tick_i    (tick_i),
      .evt_i     (evt),
      .mode_i    (mode),
      .pwrt_en_i (pwrt_en_i),
      .pll_en_i  (pll_en_i),
      .phase_d_o (phase_d)
   );

   rst_seq_flags #(.ADDR_W(ADDR_W), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_flags (
      .clk_i      (clk_osc_i),
      .rst_i      (por_i),
      .evt_i      (evt),
      .irq_en_i   (irq_en_i),
      .irq_hi_i   (irq_hi_i),
      .pc_i       (pc_i),
      .wr_i       (flag_wr_i),
      .wdata_i    (flag_wdata_i),
      .flags_o    (flags_o),
      .start_pc_o (start_pc_o)
   );

   always_ff @(posedge clk_osc_i or posedge por_i) begin
      if (por_i) core_rst_q <= 1'b1;
      else       core_rst_q <= (phase_d != PH_DONE) || evt_is_reset(evt) || pin_lvl;
   end

   assign core_rst_o = core_rst_q;

   p_pin_holds_r7: assert property (@(posedge clk_osc_i) disable iff (por_i)
      pin_lvl |=> core_rst_o);

   p_reset_pulses_r4: assert property (@(posedge clk_osc_i) disable iff (por_i)
      evt_is_reset(evt) |=> core_rst_o);
endmodule

// File: tb/rst_seq_top_bench.sv
module rst_seq_top_bench;
   localparam int AW   = 21;
   localparam int NVEC = 16;

   typedef struct packed {
      logic [2:0]    ev;
      logic [1:0]    mode;
      logic          pwrt;
      logic          pll;
      logic          ien;
      logic          ihi;
      logic [7:0]    lo;
      logic [7:0]    hi;
      logic [4:0]    fl;
      logic [AW-1:0] pc;
   } vec_t;

   // ev: 0 brown-out, 1 watchdog reset, 2 software reset, 3 pin, 4 pin in sleep,
   //     5 watchdog wake, 6 interrupt wake
   localparam vec_t VEC [NVEC] = '{
      '{3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd72, 8'd81, 5'b11101, 21'h0},
      '{3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd32, 8'd32, 5'b11101, 21'h0},
      '{3'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd81, 8'd97, 5'b11101, 21'h0},
      '{3'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd40, 8'd49, 5'b11101, 21'h0},
      '{3'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'd40, 8'd49, 5'b11101, 21'h0},
      '{3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  8'd1,  5'b11101, 21'h0},
      '{3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd32, 8'd32, 5'b11101, 21'h0},
      '{3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd72, 8'd81, 5'b10111, 21'h0},
      '{3'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  8'd1,  5'b01111, 21'h0},
      '{3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4,  8'd7,  5'b11111, 21'h0},
      '{3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd31, 8'd35, 5'b11011, 21'h0},
      '{3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd32, 8'd32, 5'b10011, 21'h1236},
      '{3'd6, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd40, 8'd49, 5'b11011, 21'h8},
      '{3'd6, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd32, 8'd32, 5'b11011, 21'h18},
      '{3'd6, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0,  5'b11011, 21'h1236},
      '{3'd5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd0,  5'b10011, 21'h1236}
   };

   logic clk = 1'b0;
   logic por = 1'b1;
   logic bor = 0, wdt = 0, sw = 0, pin = 0, wwdt = 0, wirq = 0, slp = 0;
   logic ien = 0, ihi = 0, pwrt = 1, pll = 0, tick = 0, fwr = 0;
   logic [1:0] mode = 2'd0;
   logic [4:0] fwd = '0;
   logic [AW-1:0] pc = 21'h1234;
   logic core_rst;
   logic [4:0] flags;
   logic [AW-1:0] spc;
   logic [2:0] div = '0;
   int tests = 0, fails = 0, cyc = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      div  <= div + 3'd1;
      tick <= (div == 3'd7);
   end

   rst_seq_top #(.PWRT_TICKS(6), .OST_CYCLES(32), .PLL_TICKS(2), .ADDR_W(AW)) u_rst_seq_top (
      .clk_osc_i (clk), .por_i (por), .bor_stb_i (bor), .wdt_rst_stb_i (wdt),
      .sw_rst_stb_i (sw), .pin_rst_i (pin), .wake_wdt_stb_i (wwdt),
      .wake_irq_stb_i (wirq), .sleep_i (slp), .irq_en_i (ien), .irq_hi_i (ihi),
      .osc_mode_i (mode), .pwrt_en_i (pwrt), .pll_en_i (pll), .tick_i (tick),
      .pc_i (pc), .flag_wr_i (fwr), .flag_wdata_i (fwd),
      .core_rst_o (core_rst), .flags_o (flags), .start_pc_o (spc)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected under 150000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic check_band(input string req, input int act, input int lo, input int hi);
      tests++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_flags(input logic [4:0] v);
      fwr = 1'b1; fwd = v;
      step(1);
      fwr = 1'b0;
      step(1);
   endtask

   function automatic string tag(input int i);
      case (i)
         0:  return "R2 brown-out crystal with power-up wait";
         1:  return "R3 brown-out crystal start-up only";
         2:  return "R5 brown-out high-speed with PLL";
         3:  return "R5 high-speed PLL without power-up wait";
         4:  return "R4 external clock power-up wait only";
         5:  return "R4 RC without any wait";
         6:  return "R5 PLL enable ignored outside high-speed";
         7:  return "R8 watchdog reset";
         8:  return "R8 software reset";
         9:  return "R8 pin outside sleep";
         10: return "R9 pin asserted in sleep";
         11: return "R9 watchdog wake";
         12: return "R10 high-priority interrupt wake";
         13: return "R10 low-priority interrupt wake";
         14: return "R6 interrupt wake in external clock mode";
         default: return "R6 watchdog wake in RC mode";
      endcase
   endfunction

   task automatic run_vec(input int i);
      vec_t v;
      int   high;
      v = VEC[i];
      mode = v.mode; pwrt = v.pwrt; pll = v.pll; ien = v.ien; ihi = v.ihi;
      write_flags(5'b11111);
      slp = (v.ev >= 3'd4);
      step(1);
      case (v.ev)
         3'd0: bor = 1'b1;
         3'd1: wdt = 1'b1;
         3'd2: sw = 1'b1;
         3'd3, 3'd4: pin = 1'b1;
         3'd5: wwdt = 1'b1;
         default: wirq = 1'b1;
      endcase
      high = 0;
      for (int c = 0; c < 150; c++) begin
         @(negedge clk);
         if (core_rst) high++;
         if (c == 2) begin bor = 0; wdt = 0; sw = 0; wwdt = 0; wirq = 0; end
         if (c == 4) pin = 1'b0;
      end
      slp = 1'b0;
      check_band({tag(i), " hold length"}, high, int'(v.lo), int'(v.hi));
      check({tag(i), " flags"}, 32'(flags), 32'(v.fl));
      check({tag(i), " start address"}, 32'(spc), 32'(v.pc));
   endtask

   initial begin
      int high;
      // R1: reset state while the power-on pulse is held
      step(3);
      check("R1 core held during power-on", 32'(core_rst), 32'd1);
      check("R1 flags during power-on", 32'(flags), 32'h1C);
      check("R1 start address during power-on", 32'(spc), 32'd0);
      por = 1'b0;
      high = 0;
      for (int c = 0; c < 150; c++) begin
         @(negedge clk);
         if (core_rst) high++;
      end
      check_band("R1 power-on chain length", high, 72, 83);
      check("R1 flags after power-on", 32'(flags), 32'h1C);

      for (int i = 0; i < NVEC; i++) run_vec(i);

      // R11: a software reset in the middle of a start-up count restarts it
      mode = 2'd0; pwrt = 1'b0; pll = 1'b0;
      write_flags(5'b11111);
      bor = 1'b1;
      high = 0;
      for (int c = 0; c < 150; c++) begin
         @(negedge clk);
         if (core_rst) high++;
         if (c == 2) bor = 1'b0;
         if (c == 19) sw = 1'b1;
         if (c == 22) sw = 1'b0;
      end
      check_band("R11 restart extends hold", high, 51, 53);
      check("R11 flags after both resets", 32'(flags), 32'h0D);

      // R6: wake strobe while awake is ignored
      mode = 2'd0;
      wirq = 1'b1;
      high = 0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (core_rst) high++;
         if (c == 2) wirq = 1'b0;
      end
      check("R6 wake without sleep does not stall", 32'(high), 32'd0);
      check("R6 wake without sleep keeps flags", 32'(flags), 32'h0D);
      check("R6 wake without sleep keeps address", 32'(spc), 32'd0);

      // R12: software write of the flags
      write_flags(5'b00000);
      check("R12 flags written to zero", 32'(flags), 32'd0);
      write_flags(5'b10101);
      check("R12 flags written pattern", 32'(flags), 32'h15);

      // R7: pin held through a power-on chain, released after it expired
      mode = 2'd2; pwrt = 1'b1;
      pin = 1'b1;
      por = 1'b1;
      step(3);
      por = 1'b0;
      step(120);
      check("R7 pin keeps core held after waits expired", 32'(core_rst), 32'd1);
      check("R7 pin outside sleep leaves power-on flags", 32'(flags), 32'h1C);
      pin = 1'b0;
      step(2);
      check("R7 still held two edges after pin release", 32'(core_rst), 32'd1);
      step(1);
      check("R7 released on third edge after pin release", 32'(core_rst), 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule